// File: doc/BRIEF.md
# Tap-Selected Watchdog Timer

This block is a watchdog whose time base is a slow clock tap rather than the system clock. Two free-running prescaler chains feed it four taps each. One chain is the main-oscillator timebase and the other is the sub-clock watch timer. Two configuration inputs pick the chain, and a two-bit interval field in the control register picks one of its four taps. Each rising edge of the chosen tap advances a two-bit counter. The fourth edge after the last clear wraps the counter and sends a one-cycle reset request to the chip reset logic.

Software starts the watchdog with a write that has the kick bit at 0. Once it runs, software cannot stop it. Further kick writes, and any entry into a low-power or hold state, only clear the counter. After an overflow the watchdog stops until software starts it again.

The control register also holds four reset-cause flags: power-on, watchdog, external and software. A read returns them and clears them.

Top module: `wdog_tap_top`

## Requirements
- R1: After reset, `wdt_rst_o` is 0 and `reg_rdata_o` reads 0x0C. That value is the power-on flag (bit 3), the kick bit reading as 1 (bit 2) and an interval of 0 (bits 1:0).
- R2: While stopped, tap edges have no effect and no reset request occurs. A register write with bit 2 = 0 starts the watchdog, clears the counter and loads the interval from bits 1:0.
- R3: The watch-timer taps `wt_tap_i` are used only when `wt_sel_i` and `sub_mode_i` are both 1. Otherwise the timebase taps `tb_tap_i` are used. The interval value n selects tap index n of the active chain, and edges on every other tap are ignored.
- R4: Each rising edge of the selected tap advances the counter by one. On the fourth edge after a start or clear, `wdt_rst_o` goes high for exactly one cycle, starting at the clock edge that first samples that tap edge high.
- R5: After an overflow the watchdog is stopped. Further tap edges give no reset request until a new start write.
- R6: While running, a write with bit 2 = 0 clears the counter and leaves the interval unchanged. A write with bit 2 = 1 has no effect.
- R7: While running, a pulse on any bit of `lp_enter_i` clears the counter. The bits are watch, timebase, sleep, stop and hold entry.
- R8: The cause flags read at bit 3 (power-on, set by reset), bit 4 (watchdog, set by overflow), bit 5 (external, set by `ext_rst_evt_i`) and bit 6 (software, set by `sw_rst_evt_i`). Bit 7 reads 0.
- R9: A read (`reg_rd_i` high for one cycle) returns the current flags and clears them at the following clock edge. A new set event takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| tb_tap_i | input | 4 | Timebase prescaler taps, synchronous to clk_i |
| wt_tap_i | input | 4 | Watch-timer prescaler taps, synchronous to clk_i |
| wt_sel_i | input | 1 | Watch-timer source select |
| sub_mode_i | input | 1 | Clock mode is sub-clock |
| lp_enter_i | input | 5 | Low-power/hold entry strobes |
| ext_rst_evt_i | input | 1 | External reset cause event |
| sw_rst_evt_i | input | 1 | Software reset cause event |
| reg_wr_i | input | 1 | Control register write strobe |
| reg_wdata_i | input | 8 | Control register write data |
| reg_rd_i | input | 1 | Control register read strobe |
| reg_rdata_o | output | 8 | Control register read data |
| wdt_rst_o | output | 1 | One-cycle watchdog reset request |

## Verification
The bench drives each tap high in one cycle and low in the next. A reset request is due one clock edge after a tap goes high, so the driver records in the scoreboard the exact cycle of every request it expects. The monitor samples `wdt_rst_o` at each falling edge. It fails any request that comes early, comes late, lasts longer than one cycle or was not expected. Register effects are due at the clock edge that samples the strobe. For that reason, read data is compared at the falling edge before the read strobe, and the cleared value is checked on the next read.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int IVL_W   = 2;
  localparam int N_TAPS  = 1 << IVL_W;
  localparam int REG_W   = 8;
  // control register bit positions
  localparam int IVL_LSB  = 0;
  localparam int KICK_BIT = 2;
  localparam int POR_BIT  = 3;
  localparam int WDG_BIT  = 4;
  localparam int EXT_BIT  = 5;
  localparam int SW_BIT   = 6;

  typedef struct packed {
    logic sw;
    logic ext;
    logic wdg;
    logic por;
  } cause_t;
endpackage

// File: rtl/wdog_tap_sel.sv
module wdog_tap_sel
  import wdog_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_TAPS-1:0] tb_tap_i,
  input  logic [N_TAPS-1:0] wt_tap_i,
  input  logic              use_wt_i,
  input  logic [IVL_W-1:0]  ivl_i,
  output logic              edge_o
);
  logic [N_TAPS-1:0] chain;
  logic              tap_now, tap_q;

  for (genvar g = 0; g < N_TAPS; g++) begin : g_chain
    assign chain[g] = use_wt_i ? wt_tap_i[g] : tb_tap_i[g];
  end

  assign tap_now = chain[ivl_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tap_q <= 1'b0;
    else         tap_q <= tap_now;
  end

  assign edge_o = tap_now & ~tap_q;

  p_edge_is_rise_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |=> tap_q);
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 2,
  parameter int N_LP  = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            edge_i,
  input  logic            kick_i,
  input  logic [N_LP-1:0] lp_i,
  output logic            running_o,
  output logic            ovf_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             run_q, ovf_q;
  logic             lp_any;

  assign lp_any = |lp_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= 1'b0;
      if (!run_q) begin
        if (kick_i) begin
          run_q <= 1'b1;
          cnt_q <= '0;
        end
      end else if (kick_i || lp_any) begin
        cnt_q <= '0;
      end else if (edge_i) begin
        if (cnt_q == CNT_MAX) begin
          cnt_q <= '0;
          run_q <= 1'b0;
          ovf_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign running_o = run_q;
  assign ovf_o     = ovf_q;

  p_ovf_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |=> !ovf_q);
  p_ovf_stops_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |-> !run_q);
  p_stay_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !kick_i) |=> (!run_q && !ovf_q));
  p_lp_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && lp_any) |=> (cnt_q == '0 && !ovf_q));
  p_kick_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && kick_i) |=> (run_q && cnt_q == '0));
endmodule

// File: rtl/wdog_ctrl_reg.sv
module wdog_ctrl_reg
  import wdog_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             rd_i,
  input  logic             running_i,
  input  logic             ovf_i,
  input  logic             ext_evt_i,
  input  logic             sw_evt_i,
  output logic             kick_o,
  output logic [IVL_W-1:0] ivl_o,
  output logic [REG_W-1:0] rdata_o
);
  logic [IVL_W-1:0] ivl_q;
  cause_t           cause_q;

  assign kick_o = wr_i & ~wdata_i[KICK_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ivl_q   <= '0;
      cause_q <= '{sw: 1'b0, ext: 1'b0, wdg: 1'b0, por: 1'b1};
    end else begin
      // interval is frozen once the watchdog runs
      if (kick_o && !running_i) ivl_q <= wdata_i[IVL_LSB +: IVL_W];
      if (rd_i) cause_q <= '0;
      if (ovf_i)     cause_q.wdg <= 1'b1;
      if (ext_evt_i) cause_q.ext <= 1'b1;
      if (sw_evt_i)  cause_q.sw  <= 1'b1;
    end
  end

  always_comb begin
    rdata_o = '0;
    rdata_o[IVL_LSB +: IVL_W] = ivl_q;
    rdata_o[KICK_BIT] = 1'b1;
    rdata_o[POR_BIT]  = cause_q.por;
    rdata_o[WDG_BIT]  = cause_q.wdg;
    rdata_o[EXT_BIT]  = cause_q.ext;
    rdata_o[SW_BIT]   = cause_q.sw;
  end

  assign ivl_o = ivl_q;

  p_rd_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !ovf_i && !ext_evt_i && !sw_evt_i) |=> (cause_q == '0));
  p_ovf_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_i |=> cause_q.wdg);
  p_ivl_frozen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running_i |=> $stable(ivl_q));
endmodule

// File: rtl/wdog_tap_top.sv
module wdog_tap_top
  import wdog_pkg::*;
#(
  parameter int CNT_W = 2,
  parameter int N_LP  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_TAPS-1:0] tb_tap_i,
  input  logic [N_TAPS-1:0] wt_tap_i,
  input  logic              wt_sel_i,
  input  logic              sub_mode_i,
  input  logic [N_LP-1:0]   lp_enter_i,
  input  logic              ext_rst_evt_i,
  input  logic              sw_rst_evt_i,
  input  logic              reg_wr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  input  logic              reg_rd_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              wdt_rst_o
);
  logic             use_wt, tap_edge, kick, running, ovf;
  logic [IVL_W-1:0] ivl;

  assign use_wt = wt_sel_i & sub_mode_i;

  wdog_tap_sel u_sel (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tb_tap_i (tb_tap_i),
    .wt_tap_i (wt_tap_i),
    .use_wt_i (use_wt),
    .ivl_i    (ivl),
    .edge_o   (tap_edge)
  );

  wdog_counter #(.CNT_W(CNT_W), .N_LP(N_LP)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .edge_i    (tap_edge),
    .kick_i    (kick),
    .lp_i      (lp_enter_i),
    .running_o (running),
    .ovf_o     (ovf)
  );

  wdog_ctrl_reg u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (reg_wr_i),
    .wdata_i   (reg_wdata_i),
    .rd_i      (reg_rd_i),
    .running_i (running),
    .ovf_i     (ovf),
    .ext_evt_i (ext_rst_evt_i),
    .sw_evt_i  (sw_rst_evt_i),
    .kick_o    (kick),
    .ivl_o     (ivl),
    .rdata_o   (reg_rdata_o)
  );

  assign wdt_rst_o = ovf;

  p_rst_only_running_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |-> $past(running));
endmodule

// File: tb/wdog_tap_top_test.sv
module wdog_tap_top_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] tb_tap = '0, wt_tap = '0;
  logic       wt_sel = 1'b0, sub_mode = 1'b0;
  logic [4:0] lp = '0;
  logic       ext_evt = 1'b0, sw_evt = 1'b0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       wdt_rst;

  int checks = 0, errors = 0, cyc = 0;
  int exp_q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdog_tap_top uut (
    .clk_i(clk), .rst_ni(rst_n), .tb_tap_i(tb_tap), .wt_tap_i(wt_tap),
    .wt_sel_i(wt_sel), .sub_mode_i(sub_mode), .lp_enter_i(lp),
    .ext_rst_evt_i(ext_evt), .sw_rst_evt_i(sw_evt), .reg_wr_i(wr),
    .reg_wdata_i(wdata), .reg_rd_i(rd), .reg_rdata_o(rdata), .wdt_rst_o(wdt_rst)
  );

  // monitor: every reset request must match the next expected cycle (R4, R5)
  always @(negedge clk) begin
    if (rst_n && wdt_rst) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R4/R5 unexpected reset request at cycle %0d (expected none)", cyc);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (e != cyc) begin
          errors++;
          $display("FAIL R4 reset request at cycle %0d expected %0d", cyc, e);
        end
      end
    end
  end

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic reg_read(input logic [7:0] exp, input string tag);
    @(negedge clk);
    chk(rdata, exp, tag);
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic reg_write(input logic [7:0] d);
    @(negedge clk);
    wr = 1'b1; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  // driver: one tap pulse; pushes the due cycle of the request it should cause
  task automatic tap(input bit watch, input int idx, input bit expect_rst);
    @(negedge clk);
    if (watch) wt_tap[idx] = 1'b1; else tb_tap[idx] = 1'b1;
    if (expect_rst) exp_q.push_back(cyc + 1);
    @(negedge clk);
    wt_tap = '0; tb_tap = '0;
  endtask

  task automatic taps(input bit watch, input int idx, input int n);
    for (int i = 0; i < n; i++) tap(watch, idx, 1'b0);
  endtask

  task automatic lp_pulse(input int b);
    @(negedge clk);
    lp = 5'(1 << b);
    @(negedge clk);
    lp = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog timeout");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    @(negedge clk);
    chk({7'b0, wdt_rst}, 8'h00, "R1 reset request idle");
    reg_read(8'h0C, "R1 R8 reset value");
    reg_read(8'h04, "R9 flags cleared by read");
    // R2 stopped: edges ignored
    taps(0, 0, 6);
    reg_read(8'h04, "R2 stopped, no watchdog flag");
    // R2 start with interval 2; R3 other taps/chain ignored; R4 fourth edge
    reg_write(8'h02);
    reg_read(8'h06, "R2 interval loaded");
    taps(0, 0, 2);
    taps(0, 2, 3);
    taps(1, 2, 2);
    tap(0, 2, 1'b1);
    reg_read(8'h16, "R8 watchdog flag set");
    reg_read(8'h06, "R9 watchdog flag cleared");
    // R5 stopped after overflow
    taps(0, 2, 5);
    reg_read(8'h06, "R5 no restart without write");
    // R6 kick clears, interval frozen, kick=1 write ignored
    reg_write(8'h01);
    taps(0, 1, 3);
    reg_write(8'h03);
    reg_read(8'h05, "R6 interval unchanged while running");
    taps(0, 1, 3);
    reg_write(8'h04);
    tap(0, 1, 1'b1);
    reg_read(8'h15, "R6 overflow after ignored write");
    // R7 each low-power strobe clears the counter
    for (int b = 0; b < 5; b++) begin
      reg_write(8'h00);
      taps(0, 0, 3);
      lp_pulse(b);
      taps(0, 0, 3);
      tap(0, 0, 1'b1);
    end
    reg_read(8'h14, "R7 flags after low-power runs");
    // R3 watch select alone keeps timebase chain
    wt_sel = 1'b1; sub_mode = 1'b0;
    reg_write(8'h03);
    taps(1, 3, 4);
    taps(0, 3, 3);
    tap(0, 3, 1'b1);
    // R3 both selects: watch chain
    sub_mode = 1'b1;
    reg_write(8'h03);
    taps(0, 3, 4);
    taps(1, 3, 3);
    tap(1, 3, 1'b1);
    // R8 external and software cause flags
    @(negedge clk); ext_evt = 1'b1;
    @(negedge clk); ext_evt = 1'b0; sw_evt = 1'b1;
    @(negedge clk); sw_evt = 1'b0;
    reg_read(8'h77, "R8 all cause flags");
    reg_read(8'h07, "R9 cause flags cleared");
    repeat (4) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R4 missing reset requests actual %0d expected 0", exp_q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule